// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a set of peripheral interrupt request lines and presents at most one of them at a time to a single processor. Each line carries its own software-set enable bit, priority and handler address. A line that sees a request while enabled becomes pending. The controller picks the best pending line and raises the processor request only if that line's priority is strictly above the processor's current execution level, and only while the global enable is on.

On acknowledge the selected line enters service. The controller shows that line's handler address and priority on its outputs, and the processor is expected to adopt that priority as its execution level. Entering service masks nothing, so a strictly higher line can still preempt a running handler. A line leaves service when software writes its index to the end-of-service word, or when the execution level falls through the line's priority. The processor configures all of this through a word-addressed register window at the top quarter of the 32-bit address space.

Top module: `prio_vec_intc`

## Requirements
- R1: The register window is selected when bus_addr[31:30] is 2'b11, bits [29:7] are zero and bits [1:0] are zero. Byte offset 0x00 holds the global enable in bit 0. Offset 0x04 is the end-of-service word: a write names a line by its index in the low data bits. Line k's control word is at 0x40+8k, with the enable in bit 31 and the priority in bits [3:0]. Line k's handler address is at 0x44+8k. Reads return the stored values. Accesses outside the window change nothing.
- R2: An enabled line that is idle becomes pending at the clock edge that sees a request edge on it. Lines 0 to 3 (the default both-edge mask) react to both rising and falling inputs. The other lines react only to rising inputs. Edges on a disabled line are dropped.
- R3: Among the pending lines, the one with the highest priority is selected, and ties go to the lowest index. While int_req is high, ack_vector and ack_prio carry that line's handler address and priority.
- R4: int_req is high only when the global enable is set and the selected priority is strictly greater than exec_level.
- R5: int_ack while int_req is high moves the selected line into service. A later pending line is presented during that service only if its priority is strictly greater than the raised exec_level.
- R6: Writing a line's enable to 0 discards its pending request and any request remembered during service.
- R7: Clearing the global enable holds back int_req but keeps pending lines. They are presented again once the enable is set.
- R8: A line in service returns to idle on an end-of-service write naming it, or when exec_level drops from at least its priority to below it between two clock edges.
- R9: A request edge on an enabled line in service is remembered. The line becomes pending one clock edge after it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Request lines, synchronous to clk |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high |
| exec_level | input | PRIO_W | Processor's current execution level |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Processor acknowledge |
| ack_vector | output | VEC_W | Handler address of the selected line |
| ack_prio | output | PRIO_W | Priority of the selected line |

## Verification
A request edge driven between clock edges becomes pending at the next edge, so int_req, ack_vector and ack_prio are checked one cycle later. Register writes, acknowledges and enable changes take effect at the edge that samples them and are checked in the half cycle that follows. A request remembered during service needs two edges after end of service: one to return to idle and one to become pending. The bench drives all inputs on the falling clock edge and samples each result on the falling edge after the rising edge that produces it.

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int NLINES = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W = 32,
  parameter logic [NLINES-1:0] BOTH_EDGE_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PRIO_W-1:0] exec_level,
  output logic              int_req,
  input  logic              int_ack,
  output logic [VEC_W-1:0]  ack_vector,
  output logic [PRIO_W-1:0] ack_prio
);
  localparam int WORDS = 16 + 2 * NLINES;
  localparam int IDX_W = $clog2(WORDS);
  localparam int SEL_W = $clog2(NLINES);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_SCHED = 2'd1, ST_SERV = 2'd2;

  logic [1:0]        st    [NLINES];
  logic              again [NLINES];
  logic              en    [NLINES];
  logic [PRIO_W-1:0] prio  [NLINES];
  logic [VEC_W-1:0]  vec   [NLINES];
  logic [NLINES-1:0] irq_q, edge_hit;
  logic [PRIO_W-1:0] exec_q, best;
  logic [SEL_W-1:0]  sel;
  logic              gie, found, ack_go, in_win, eos_wr;
  logic [IDX_W-1:0]  word;

  assign in_win = bus_addr[31:30] == 2'b11 && bus_addr[29:IDX_W+2] == '0 && bus_addr[1:0] == 2'b00;
  assign word = bus_addr[IDX_W+1:2];
  assign eos_wr = bus_wr && in_win && word == IDX_W'(1);
  assign edge_hit = (irq_in & ~irq_q) | ((irq_in ^ irq_q) & BOTH_EDGE_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      exec_q <= '0;
      gie <= 1'b0;
    end else begin
      irq_q <= irq_in;
      exec_q <= exec_level;
      if (bus_wr && in_win && word == IDX_W'(0)) gie <= bus_wdata[0];
    end
  end

  always_comb begin
    found = 1'b0;
    sel = '0;
    best = '0;
    for (int k = 0; k < NLINES; k++) begin
      if (st[k] == ST_SCHED && (!found || prio[k] > best)) begin
        found = 1'b1;
        sel = SEL_W'(k);
        best = prio[k];
      end
    end
  end

  assign int_req = gie && found && best > exec_level;
  assign ack_go = int_ack && int_req;
  assign ack_vector = vec[sel];
  assign ack_prio = best;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && in_win) begin
      if (word == IDX_W'(0)) bus_rdata = {31'd0, gie};
      for (int k = 0; k < NLINES; k++) begin
        if (word == IDX_W'(16 + 2 * k)) bus_rdata = {en[k], 31'(prio[k])};
        if (word == IDX_W'(17 + 2 * k)) bus_rdata = 32'(vec[k]);
      end
    end
  end

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    logic cfg_wr, vec_wr, en_eff, hit, eos_k, drop_k;
    assign cfg_wr = bus_wr && in_win && word == IDX_W'(16 + 2 * k);
    assign vec_wr = bus_wr && in_win && word == IDX_W'(17 + 2 * k);
    assign en_eff = cfg_wr ? bus_wdata[31] : en[k];
    assign hit = edge_hit[k] && en_eff;
    assign eos_k = eos_wr && bus_wdata[SEL_W-1:0] == SEL_W'(k);
    assign drop_k = exec_q >= prio[k] && exec_level < prio[k];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[k] <= 1'b0;
        prio[k] <= '0;
        vec[k] <= '0;
      end else begin
        if (cfg_wr) begin
          en[k] <= bus_wdata[31];
          prio[k] <= bus_wdata[PRIO_W-1:0];
        end
        if (vec_wr) vec[k] <= bus_wdata[VEC_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[k] <= ST_IDLE;
        again[k] <= 1'b0;
      end else begin
        case (st[k])
          ST_IDLE: if (en_eff && (hit || again[k])) begin
            st[k] <= ST_SCHED;
            again[k] <= 1'b0;
          end
          ST_SCHED: if (!en_eff) st[k] <= ST_IDLE;
                    else if (ack_go && sel == SEL_W'(k)) st[k] <= ST_SERV;
          ST_SERV: begin
            if (hit) again[k] <= 1'b1;
            if (eos_k || drop_k) st[k] <= ST_IDLE;
          end
          default: st[k] <= ST_IDLE;
        endcase
        if (!en_eff) again[k] <= 1'b0;
      end
    end

    AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_go && sel == SEL_W'(k)) |=> st[k] == ST_SERV); // R5
    AST_DISABLED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !en[k] |-> (st[k] != ST_SCHED && !again[k])); // R6
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st[k] == ST_IDLE && !en[k] && !cfg_wr) |=> st[k] == ST_IDLE); // R2
    AST_GIE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie && st[k] == ST_SCHED && !cfg_wr) |=> st[k] == ST_SCHED); // R7
  end

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> gie); // R4
  AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ack_prio > exec_level); // R4
endmodule

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, int_ack = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata, ack_vector;
  logic [3:0] exec_level = '0, ack_prio;
  logic int_req;
  int n_checks = 0, n_fail = 0;

  localparam int PRI [8] = '{1, 3, 5, 5, 2, 7, 4, 6};
  localparam logic [15:0] TBL [10] = '{
    {8'h01, 4'd0, 1'b1, 3'd0}, {8'h03, 4'd0, 1'b1, 3'd1},
    {8'h0C, 4'd0, 1'b1, 3'd2}, {8'h2C, 4'd0, 1'b1, 3'd5},
    {8'h2C, 4'd7, 1'b0, 3'd0}, {8'h0C, 4'd4, 1'b1, 3'd2},
    {8'h0C, 4'd5, 1'b0, 3'd0}, {8'hFF, 4'd6, 1'b1, 3'd5},
    {8'h50, 4'd3, 1'b1, 3'd6}, {8'h10, 4'd2, 1'b0, 3'd0}};

  prio_vec_intc dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .exec_level(exec_level), .int_req(int_req), .int_ack(int_ack),
    .ack_vector(ack_vector), .ack_prio(ack_prio));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic bus_write(logic [31:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [31:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_line(int k, bit en);
    bus_write(32'hC000_0040 + 32'(8 * k), {en, 27'd0, 4'(PRI[k])});
  endtask

  task automatic reset_lines();
    for (int k = 0; k < 8; k++) set_line(k, 1'b0);
    for (int k = 0; k < 8; k++) set_line(k, 1'b1);
  endtask

  task automatic pulse(int k);
    irq_in[k] = 1'b1; step(); irq_in[k] = 1'b0;
  endtask

  task automatic ack();
    int_ack = 1'b1; step(); int_ack = 1'b0;
  endtask

  task automatic expect_line(string tag, int k);
    check(tag, {31'd0, int_req}, 32'd1);
    check(tag, ack_vector, 32'h1000 + 32'(16 * k));
    check(tag, {28'd0, ack_prio}, 32'(PRI[k]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    step(); step(); rst_n = 1'b1; step();
    check("reset int_req", {31'd0, int_req}, 0);
    bus_read(32'hC000_0000, rd); check("reset R1 gie", rd, 0);
    bus_read(32'hC000_0040, rd); check("reset R1 cfg0", rd, 0);

    for (int k = 0; k < 8; k++) begin
      set_line(k, 1'b1);
      bus_write(32'hC000_0044 + 32'(8 * k), 32'h1000 + 32'(16 * k));
    end
    bus_write(32'hC000_0000, 1);
    bus_read(32'hC000_0000, rd); check("R1 gie readback", rd, 1);
    bus_read(32'hC000_0068, rd); check("R1 cfg5 readback", rd, 32'h8000_0007);
    bus_read(32'hC000_006C, rd); check("R1 vec5 readback", rd, 32'h1050);
    bus_write(32'h4000_006C, 32'h0);
    bus_write(32'hC000_006E, 32'h0);
    bus_read(32'hC000_006C, rd); check("R1 outside window ignored", rd, 32'h1050);

    // table walk: R3 selection and ties, R4 strict level compare
    for (int i = 0; i < 10; i++) begin
      irq_in = TBL[i][15:8]; exec_level = TBL[i][7:4];
      step();
      irq_in = '0;
      check($sformatf("R4 table %0d req", i), {31'd0, int_req}, {31'd0, TBL[i][3]});
      if (TBL[i][3]) begin
        check($sformatf("R3 table %0d vector", i), ack_vector, 32'h1000 + 32'(16 * TBL[i][2:0]));
        check($sformatf("R3 table %0d prio", i), {28'd0, ack_prio}, 32'(PRI[TBL[i][2:0]]));
      end
      step();
      reset_lines();
    end
    exec_level = 0;

    // R2 edge kinds
    irq_in[0] = 1'b1; step(); expect_line("R2 line0 rise", 0);
    reset_lines();
    irq_in[0] = 1'b0; step(); expect_line("R2 line0 fall", 0);
    reset_lines();
    irq_in[4] = 1'b1; step(); expect_line("R2 line4 rise", 4);
    reset_lines();
    irq_in[4] = 1'b0; step(); check("R2 line4 fall ignored", {31'd0, int_req}, 0);
    set_line(6, 1'b0); pulse(6); step();
    set_line(6, 1'b1); step();
    check("R2 disabled edge dropped", {31'd0, int_req}, 0);

    // R5 preemption, R9 remembered request, R8 exits
    pulse(1); expect_line("R5 line1 offered", 1);
    ack(); exec_level = 3;
    check("R5 after ack", {31'd0, int_req}, 0);
    pulse(0); check("R5 lower waits", {31'd0, int_req}, 0);
    pulse(5); expect_line("R5 higher preempts", 5);
    ack(); exec_level = 7; step();
    check("R5 nested serviced", {31'd0, int_req}, 0);
    bus_write(32'hC000_0004, 5); exec_level = 3; step();
    check("R8 line5 ended, line0 still below", {31'd0, int_req}, 0);
    pulse(1); step();
    check("R9 re-request held in service", {31'd0, int_req}, 0);
    bus_write(32'hC000_0004, 1);
    check("R9 idle one edge after end", {31'd0, int_req}, 0);
    exec_level = 0; step();
    expect_line("R9 rescheduled", 1);
    ack(); exec_level = 3; step(); step();
    exec_level = 0; step();
    expect_line("R8 line0 after level drop", 0);
    pulse(1); expect_line("R8 line1 idle again", 1);
    reset_lines();

    // R7 global disable keeps pending
    bus_write(32'hC000_0000, 0);
    pulse(2); check("R7 blocked", {31'd0, int_req}, 0);
    step(); check("R7 still blocked", {31'd0, int_req}, 0);
    bus_write(32'hC000_0000, 1);
    expect_line("R7 delivered on re-enable", 2);
    reset_lines();

    // R6 local disable clears pending
    pulse(3); expect_line("R6 pending", 3);
    set_line(3, 1'b0); check("R6 cleared", {31'd0, int_req}, 0);
    set_line(3, 1'b1); step(); check("R6 stays cleared", {31'd0, int_req}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule